// File: doc/BRIEF.md
# Block Copy DMA Engine

This block copies a run of bytes from anywhere in a 16-bit address space into a fixed 8 KiB video-memory window at 0x8000–0x9FFF. Software loads a source pointer and a destination pointer through four byte-wide registers on a small register bus. It then writes a control register that carries a mode bit and a length counted in 16-byte blocks. The source is snapped down to a 16-byte boundary. The destination is folded into the window and also aligned to 16 bytes. A start is refused without any effect when the aligned source itself falls inside the window.

An accepted immediate-mode start drives a byte-wide master port and holds the CPU stalled. For each byte the block spends one read cycle at the source address and one write cycle at the destination address. When the last byte lands, the top bit of the control register is set as a done flag. A start with the mode bit set records a per-scanline mode request and copies nothing.

Top module: `blk_copy_dma`

## Requirements
- R1: The first source address of a copy is {src_hi, src_lo} with bits 3:0 forced to zero.
- R2: The destination address of a copy is ({dst_hi, dst_lo} AND 0x1FF0) OR 0x8000, so every write lands in 0x8000–0x9FFF.
- R3: A control write whose aligned source lies in 0x8000–0x9FFF starts nothing and leaves the control readback, the mode flag and the memory port unchanged.
- R4: Bit 7 of an accepted control write sets hblank_mode_o to that bit's value. A value of 1 starts no copy; a value of 0 starts a copy.
- R5: A copy moves exactly (control[6:0] + 1) × 16 bytes, from 16 up to 2048.
- R6: An accepted control write reads back with bit 7 cleared while the copy runs.
- R7: Each byte takes a read cycle (mem_rd_o high, address = current source) followed at once by a write cycle (mem_wr_o high, address = current destination, data = the byte read). Both addresses then advance by one.
- R8: busy_o and cpu_stall_o go high in the cycle after an accepted start and stay high for exactly 2 cycles per byte. While they are low, the memory port is idle.
- R9: When the last byte is written, bit 7 of the control readback becomes 1.
- R10: The register index map is 0 = source high, 1 = source low, 2 = destination high, 3 = destination low, 4 = control, and indices 5–7 read 0. The four pointer registers read back what was last written and start nothing.
- R11: A control write made while busy_o is high is ignored.
- R12: Reset clears every register, busy_o, cpu_stall_o, hblank_mode_o and the memory strobes, and it aborts a running copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index for write and readback |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Readback of the indexed register |
| mem_addr_o | output | 16 | Master port address |
| mem_rd_o | output | 1 | Master read strobe; data returns on mem_rdata_i one cycle later |
| mem_rdata_i | input | 8 | Master read data |
| mem_wr_o | output | 1 | Master write strobe |
| mem_wdata_o | output | 8 | Master write data |
| busy_o | output | 1 | Copy in progress |
| cpu_stall_o | output | 1 | CPU hold request during a copy |
| hblank_mode_o | output | 1 | Latched per-scanline mode request |

## Verification
The copy is driven with an unaligned source and an out-of-range destination, which separates the alignment masking from the window folding. The shortest length and the longest length are both used, which separates correct length decoding from off-by-one and truncated counters. Control writes are issued with a source inside the window, with the mode bit set, and while a copy is running; each must leave the port idle or the running copy undisturbed, and those three cases distinguish the three rejection paths. A reset in the middle of a copy shows that the sequencer aborts cleanly rather than merely ending at a block boundary.

// File: rtl/blk_dma_pkg.sv
package blk_dma_pkg;
  typedef enum logic [2:0] {
    REG_SRC_HI = 3'd0,
    REG_SRC_LO = 3'd1,
    REG_DST_HI = 3'd2,
    REG_DST_LO = 3'd3,
    REG_CTRL   = 3'd4
  } reg_idx_e;

  typedef enum logic {
    PH_READ  = 1'b0,
    PH_WRITE = 1'b1
  } phase_e;
endpackage

// File: rtl/dma_regfile.sv
module dma_regfile
  import blk_dma_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              accept_i,
  input  logic              done_i,
  output logic [DATA_W-1:0] src_hi_o,
  output logic [DATA_W-1:0] src_lo_o,
  output logic [DATA_W-1:0] dst_hi_o,
  output logic [DATA_W-1:0] dst_lo_o,
  output logic              hblank_o,
  output logic              done_flag_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int NPTR = 4;

  logic [DATA_W-1:0] ptr_q [NPTR];
  logic [DATA_W-1:0] ctrl_q;
  logic              hblank_q;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             ptr_q[g] <= '0;
      else if (we_i && idx_i == 3'(g))         ptr_q[g] <= wdata_i;
    end
  end

  // accept comes from the start decoder; done sets the top bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      hblank_q <= 1'b0;
    end else if (accept_i) begin
      ctrl_q   <= {1'b0, wdata_i[DATA_W-2:0]};
      hblank_q <= wdata_i[DATA_W-1];
    end else if (done_i) begin
      ctrl_q[DATA_W-1] <= 1'b1;
    end
  end

  always_comb begin
    case (idx_i)
      REG_SRC_HI: rdata_o = ptr_q[0];
      REG_SRC_LO: rdata_o = ptr_q[1];
      REG_DST_HI: rdata_o = ptr_q[2];
      REG_DST_LO: rdata_o = ptr_q[3];
      REG_CTRL:   rdata_o = ctrl_q;
      default:    rdata_o = '0;
    endcase
  end

  assign src_hi_o    = ptr_q[0];
  assign src_lo_o    = ptr_q[1];
  assign dst_hi_o    = ptr_q[2];
  assign dst_lo_o    = ptr_q[3];
  assign hblank_o    = hblank_q;
  assign done_flag_o = ctrl_q[DATA_W-1];
endmodule

// File: rtl/dma_start_decode.sv
module dma_start_decode #(
  parameter int          DATA_W    = 8,
  parameter int          BLK_SHIFT = 4,
  parameter int          WIN_TAG_W = 3,
  parameter logic [WIN_TAG_W-1:0] WIN_TAG = 3'b100,
  localparam int         ADDR_W    = 2 * DATA_W,
  localparam int         LEN_W     = DATA_W - 1,
  localparam int         CNT_W     = LEN_W + BLK_SHIFT + 1
) (
  input  logic [DATA_W-1:0] src_hi_i,
  input  logic [DATA_W-1:0] src_lo_i,
  input  logic [DATA_W-1:0] dst_hi_i,
  input  logic [DATA_W-1:0] dst_lo_i,
  input  logic              ctrl_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  output logic              accept_o,
  output logic              start_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [CNT_W-1:0]  count_o
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << BLK_SHIFT) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] OFF_MASK   = (ADDR_W'(1) << (ADDR_W - WIN_TAG_W)) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] DST_MASK   = OFF_MASK & ALIGN_MASK;
  localparam logic [ADDR_W-1:0] WIN_BASE   = ADDR_W'(WIN_TAG) << (ADDR_W - WIN_TAG_W);

  logic [ADDR_W-1:0] src_tag;
  logic              src_in_win;
  logic [LEN_W-1:0]  len;

  assign src_o      = {src_hi_i, src_lo_i} & ALIGN_MASK;
  assign dst_o      = ({dst_hi_i, dst_lo_i} & DST_MASK) | WIN_BASE;
  assign src_tag    = src_o >> (ADDR_W - WIN_TAG_W);
  assign src_in_win = (src_tag == ADDR_W'(WIN_TAG));

  assign len     = wdata_i[LEN_W-1:0];
  assign count_o = (CNT_W'(len) + CNT_W'(1)) << BLK_SHIFT;

  assign accept_o = ctrl_wr_i && !busy_i && !src_in_win;
  assign start_o  = accept_o && !wdata_i[DATA_W-1];
endmodule

// File: rtl/dma_copy_engine.sv
module dma_copy_engine
  import blk_dma_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 12,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  logic              busy_q;
  phase_e            phase_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              last_byte;

  assign last_byte = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= PH_READ;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      phase_q <= PH_READ;
      src_q   <= src_i;
      dst_q   <= dst_i;
      cnt_q   <= count_i;
    end else if (busy_q) begin
      if (phase_q == PH_READ) begin
        phase_q <= PH_WRITE;
      end else begin
        phase_q <= PH_READ;
        src_q   <= src_q + ADDR_W'(1);
        dst_q   <= dst_q + ADDR_W'(1);
        cnt_q   <= cnt_q - CNT_W'(1);
        if (last_byte) busy_q <= 1'b0;
      end
    end
  end

  assign done_o      = busy_q && (phase_q == PH_WRITE) && last_byte;
  assign busy_o      = busy_q;
  assign mem_rd_o    = busy_q && (phase_q == PH_READ);
  assign mem_wr_o    = busy_q && (phase_q == PH_WRITE);
  assign mem_addr_o  = (phase_q == PH_WRITE) ? dst_q : src_q;
  // synchronous memory: byte read last cycle is on mem_rdata_i now
  assign mem_wdata_o = mem_rdata_i;
endmodule

// File: rtl/blk_copy_dma.sv
module blk_copy_dma
  import blk_dma_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BLK_SHIFT = 4,
  parameter int WIN_TAG_W = 3,
  parameter logic [WIN_TAG_W-1:0] WIN_TAG = 3'b100,
  localparam int ADDR_W   = 2 * DATA_W,
  localparam int CNT_W    = DATA_W + BLK_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              busy_o,
  output logic              cpu_stall_o,
  output logic              hblank_mode_o
);
  logic [DATA_W-1:0] src_hi, src_lo, dst_hi, dst_lo;
  logic              ctrl_wr, accept, start, done, busy, done_flag;
  logic [ADDR_W-1:0] src_al, dst_win;
  logic [CNT_W-1:0]  count;

  assign ctrl_wr = reg_we_i && (reg_addr_i == REG_CTRL);

  dma_regfile #(.DATA_W(DATA_W)) u_regfile (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .idx_i       (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .accept_i    (accept),
    .done_i      (done),
    .src_hi_o    (src_hi),
    .src_lo_o    (src_lo),
    .dst_hi_o    (dst_hi),
    .dst_lo_o    (dst_lo),
    .hblank_o    (hblank_mode_o),
    .done_flag_o (done_flag),
    .rdata_o     (reg_rdata_o)
  );

  dma_start_decode #(
    .DATA_W    (DATA_W),
    .BLK_SHIFT (BLK_SHIFT),
    .WIN_TAG_W (WIN_TAG_W),
    .WIN_TAG   (WIN_TAG)
  ) u_decode (
    .src_hi_i  (src_hi),
    .src_lo_i  (src_lo),
    .dst_hi_i  (dst_hi),
    .dst_lo_i  (dst_lo),
    .ctrl_wr_i (ctrl_wr),
    .wdata_i   (reg_wdata_i),
    .busy_i    (busy),
    .accept_o  (accept),
    .start_o   (start),
    .src_o     (src_al),
    .dst_o     (dst_win),
    .count_o   (count)
  );

  dma_copy_engine #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .src_i       (src_al),
    .dst_i       (dst_win),
    .count_i     (count),
    .mem_rdata_i (mem_rdata_i),
    .busy_o      (busy),
    .done_o      (done),
    .mem_addr_o  (mem_addr_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_wdata_o (mem_wdata_o)
  );

  assign busy_o      = busy;
  assign cpu_stall_o = busy;
endmodule

// File: rtl/blk_copy_dma_chk.sv
module blk_copy_dma_chk #(
  parameter logic [2:0] WIN_TAG = 3'b100
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_i,
  input logic       stall_i,
  input logic       rd_i,
  input logic       wr_i,
  input logic [2:0] addr_top_i,
  input logic [3:0] addr_low_i,
  input logic       done_flag_i
);
  assert_rw_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_i, wr_i}));

  assert_read_then_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> wr_i);

  assert_dst_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> (addr_top_i == WIN_TAG));

  assert_src_outside_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && $rose(busy_i)) |-> (addr_top_i != WIN_TAG));

  assert_first_read_aligned_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> (rd_i && addr_low_i == 4'h0));

  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!rd_i && !wr_i && !stall_i));

  assert_done_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> done_flag_i);
endmodule

bind blk_copy_dma blk_copy_dma_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_i      (busy_o),
  .stall_i     (cpu_stall_o),
  .rd_i        (mem_rd_o),
  .wr_i        (mem_wr_o),
  .addr_top_i  (mem_addr_o[15:13]),
  .addr_low_i  (mem_addr_o[3:0]),
  .done_flag_i (done_flag)
);

// File: tb/blk_copy_dma_test.sv
module blk_copy_dma_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd4;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_rdata = 8'h00;
  logic [7:0]  mem_wdata;
  logic        busy, stall, hb;

  int checks = 0;
  int fails  = 0;
  bit done_run = 1'b0;

  always #4 clk = ~clk;

  blk_copy_dma uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mem_addr_o(mem_addr),
    .mem_rd_o(mem_rd), .mem_rdata_i(mem_rdata), .mem_wr_o(mem_wr),
    .mem_wdata_o(mem_wdata), .busy_o(busy), .cpu_stall_o(stall), .hblank_mode_o(hb)
  );

  function automatic logic [7:0] pat(input logic [15:0] a);
    return (a[7:0] ^ a[15:8]) + 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // memory model: one-cycle read latency, writes logged
  byte unsigned wr_log[int];
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= pat(mem_addr);
    if (mem_wr) wr_log[int'(mem_addr)] = mem_wdata;
  end

  // reference model
  logic [7:0] m_reg[5];
  bit         m_hb;
  int         q_addr[$];
  bit         q_wr[$];
  int         q_data[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) m_reg[i] = 8'h00;
      m_hb = 1'b0;
      q_addr.delete(); q_wr.delete(); q_data.delete();
    end else begin
      bit was_busy;
      was_busy = (q_addr.size() > 0);
      if (was_busy) begin
        void'(q_addr.pop_front()); void'(q_wr.pop_front()); void'(q_data.pop_front());
        if (q_addr.size() == 0) m_reg[4] = m_reg[4] | 8'h80;
      end
      if (reg_we) begin
        if (reg_addr < 3'd4) m_reg[reg_addr] = reg_wdata;
        else if (reg_addr == 3'd4 && !was_busy) begin
          int s, d, n;
          s = {m_reg[0], m_reg[1]} & 16'hFFF0;
          d = ({m_reg[2], m_reg[3]} & 16'h1FF0) | 16'h8000;
          if (!(s >= 16'h8000 && s <= 16'h9FFF)) begin
            m_reg[4] = reg_wdata & 8'h7F;
            m_hb = reg_wdata[7];
            if (!reg_wdata[7]) begin
              n = (int'(reg_wdata & 8'h7F) + 1) * 16;
              for (int k = 0; k < n; k++) begin
                q_addr.push_back((s + k) & 16'hFFFF); q_wr.push_back(1'b0); q_data.push_back(0);
                q_addr.push_back((d + k) & 16'hFFFF); q_wr.push_back(1'b1);
                q_data.push_back(int'(pat(16'((s + k) & 16'hFFFF))));
              end
            end
          end
        end
      end
    end
  end

  // per-cycle comparison away from the edge
  always @(negedge clk) begin
    if (rst_n && !done_run) begin
      bit eb;
      logic [7:0] er;
      eb = (q_addr.size() > 0);
      chk(busy == eb, "R8 busy", busy, eb);
      chk(stall == eb, "R8 stall", stall, eb);
      if (eb) begin
        chk(mem_rd == !q_wr[0], "R7 rd strobe", mem_rd, !q_wr[0]);
        chk(mem_wr == q_wr[0], "R7 wr strobe", mem_wr, q_wr[0]);
        chk(int'(mem_addr) == q_addr[0], "R7 address", mem_addr, q_addr[0]);
        if (q_wr[0]) chk(int'(mem_wdata) == q_data[0], "R7 write data", mem_wdata, q_data[0]);
      end else begin
        chk(!mem_rd && !mem_wr, "R8 idle port", {mem_rd, mem_wr}, 0);
      end
      chk(hb == m_hb, "R4 mode flag", hb, m_hb);
      er = (reg_addr < 3'd5) ? m_reg[reg_addr] : 8'h00;
      chk(reg_rdata == er, "R10 readback", reg_rdata, er);
    end
  end

  task automatic wr_reg(input logic [2:0] i, input logic [7:0] v);
    @(negedge clk); #1;
    reg_we = 1'b1; reg_addr = i; reg_wdata = v;
    @(negedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] i, output logic [7:0] v);
    @(negedge clk); #1;
    reg_addr = i;
    #1 v = reg_rdata;
  endtask

  task automatic set_ptrs(input logic [15:0] s, input logic [15:0] d);
    wr_reg(3'd0, s[15:8]); wr_reg(3'd1, s[7:0]);
    wr_reg(3'd2, d[15:8]); wr_reg(3'd3, d[7:0]);
  endtask

  // start a copy right after the pointers; returns stalled cycles
  task automatic run_copy(input logic [7:0] ctl, output int cyc, output int first_rd);
    wr_reg(3'd4, ctl);
    cyc = 0;
    first_rd = int'(mem_addr);
    while (busy) begin
      cyc++;
      @(negedge clk); #1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int cyc, frd;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;

    // R12: reset state
    chk(!busy && !stall && !hb && !mem_rd && !mem_wr, "R12 reset outputs",
        {busy, stall, hb, mem_rd, mem_wr}, 0);
    for (int i = 0; i < 8; i++) begin
      rd_reg(3'(i), v);
      chk(v == 8'h00, "R12 reset register", v, 0);
    end

    // R10: pointer registers are plain storage
    set_ptrs(16'hA5C3, 16'h1E2F);
    rd_reg(3'd0, v); chk(v == 8'hA5, "R10 src_hi", v, 8'hA5);
    rd_reg(3'd3, v); chk(v == 8'h2F, "R10 dst_lo", v, 8'h2F);
    rd_reg(3'd6, v); chk(v == 8'h00, "R10 unmapped index", v, 0);
    chk(!busy, "R10 no start from pointers", busy, 0);

    // R1 R2 R5 R8 R9: shortest copy, unaligned source, out-of-window destination
    wr_log.delete();
    set_ptrs(16'h1234, 16'h3456);
    run_copy(8'h00, cyc, frd);
    chk(frd == 16'h1230, "R1 first source", frd, 16'h1230);
    chk(cyc == 32, "R8 stall cycles", cyc, 32);
    chk(wr_log.num() == 16, "R5 bytes written", wr_log.num(), 16);
    chk(wr_log.exists(16'h9450) && wr_log.exists(16'h945F), "R2 destination span", wr_log.num(), 16);
    chk(wr_log.exists(16'h9450) && wr_log[16'h9450] == pat(16'h1230), "R7 first byte",
        wr_log.exists(16'h9450) ? wr_log[16'h9450] : -1, pat(16'h1230));
    rd_reg(3'd4, v); chk(v == 8'h80, "R9 done flag", v, 8'h80);

    // R6 R11: control write while busy ignored
    wr_log.delete();
    set_ptrs(16'h4000, 16'hE000);
    wr_reg(3'd4, 8'h03);
    rd_reg(3'd4, v); chk(v == 8'h03, "R6 bit7 cleared while busy", v, 8'h03);
    wr_reg(3'd4, 8'h10);
    rd_reg(3'd4, v); chk(v == 8'h03, "R11 busy write ignored", v, 8'h03);
    while (busy) begin @(negedge clk); #1; end
    chk(wr_log.num() == 64, "R11 length unchanged", wr_log.num(), 64);
    chk(wr_log.exists(16'h8000) && wr_log.exists(16'h803F), "R2 window fold", wr_log.num(), 64);

    // R4: mode bit set records flag, copies nothing
    wr_reg(3'd4, 8'h85);
    rd_reg(3'd4, v); chk(v == 8'h05, "R4 mode write readback", v, 8'h05);
    chk(hb && !busy, "R4 mode flag set, no copy", {hb, busy}, 2);

    // R3: source inside window rejected
    set_ptrs(16'h8ABC, 16'h0000);
    wr_reg(3'd4, 8'h01);
    rd_reg(3'd4, v); chk(v == 8'h05, "R3 control unchanged", v, 8'h05);
    chk(hb && !busy && !mem_rd, "R3 nothing started", {hb, busy, mem_rd}, 4);

    // R4 R5: immediate start clears mode flag; longest length
    wr_log.delete();
    set_ptrs(16'hC00F, 16'h0123);
    run_copy(8'h7F, cyc, frd);
    chk(!hb, "R4 mode flag cleared", hb, 0);
    chk(cyc == 4096, "R8 longest stall", cyc, 4096);
    chk(wr_log.num() == 2048, "R5 longest length", wr_log.num(), 2048);
    chk(frd == 16'hC000, "R1 aligned source", frd, 16'hC000);

    // R12: reset in the middle of a copy
    set_ptrs(16'h2000, 16'h0000);
    wr_reg(3'd4, 8'h02);
    repeat (5) @(negedge clk);
    #1 rst_n = 1'b0;
    #2 chk(!busy && !stall && !mem_rd && !mem_wr, "R12 abort", {busy, mem_rd, mem_wr}, 0);
    @(negedge clk); #1 rst_n = 1'b1;
    rd_reg(3'd0, v); chk(v == 8'h00, "R12 regs cleared", v, 0);
    repeat (4) @(negedge clk);
    chk(!busy, "R12 stays idle", busy, 0);

    done_run = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule